// File: doc/BRIEF.md
# Memory PHY Initialization Step Sequencer

This block runs the bring-up steps of a DDR3 memory PHY in response to a single 32-bit control word. Software writes the control word with one enable bit per step plus a start bit. The block then works through the selected steps in a fixed order. Each step is a request/acknowledge exchange with the circuitry that really does the work: the DLL, the impedance calibrator, the timing module, the DRAM reset and init logic, and the read training engines. At most one request is raised at a time, and each request stays high until the step's done input is seen.

Bypass bits drop steps from a run. Enabling RV training pulls gate training in with it, unless the loopback-gate input is high. An error reported by any step ends the run early. A separate read-only status word holds the run, training and drift flags. The control word also carries a self-clearing command that wipes the training and drift flags. The completion output has two modes. It can mean that the PHY itself is ready, or that the whole triggered sequence has finished.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, no step request is raised and the completion output is 0.
- R2: Control word (offset 0x04) writable bits are 1..8, 16, 17, 18, 29, 30 and 31. Every other bit reads 0. Bit 0 (start) reads 1 exactly while a run is busy and 0 otherwise.
- R3: A run raises one-hot `step_req` bits, one at a time, in this order. Bit 0 is DLL soft reset (enable bit 1), then bit 1 DLL lock (bit 2), bit 2 impedance calibration (bit 3), bit 3 timing soft reset (bit 4), bit 4 DRAM reset (bit 5), bit 5 DRAM init (bit 6), bit 6 gate training (bit 7) and bit 7 RV training (bit 8). A request holds until `step_done`, and the next enabled step is requested in the following cycle.
- R4: Steps that are not enabled or are bypassed take no cycles. Bit 17 removes both DLL steps, bit 29 removes DLL lock, bit 30 removes impedance calibration, bit 18 removes DRAM init and bit 31 removes every step. A run with nothing left completes one cycle after the start write.
- R5: Enable bit 8 also runs gate training even when bit 7 is 0. When `lb_gate_only` is 1 at the start write, gate training is left out.
- R6: `step_done` with `step_err` ends the run. No later step is requested, the sequence-error flag sets and the init-done flag still sets.
- R7: A start written while busy is ignored. The other bits of that write are still stored.
- R8: With bit 16 at 0, `init_done_pin` follows the PHY-ready flag. That flag sets once the run has moved past the impedance-calibration position, even while later steps are still running. With bit 16 at 1 it follows the init-done flag, so it is 0 throughout a busy run.
- R9: Status word (offset 0x08) bits are: 0 init done, 1 PHY ready, 2 sequence error, 3 training done, 4 training error, 5 training intermittent error, 6 drift error, 7 busy. An accepted start clears bits 0-2 and never clears bit 6. A `drift_evt` pulse sets bit 6.
- R10: Writing 1 to control bit 28 clears status bits 3-6. Bit 28 always reads 0.
- R11: A start whose run includes a training step clears status bits 3-5. Gate or RV done without error sets bit 3, with error sets bit 4. `lane_ierr` during a training step sets bit 5.
- R12: `step_done` and `step_err` while idle change neither the status word nor the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lb_gate_only | input | 1 | Loopback option: leave gate training out of the next run |
| step_req | output | 8 | One-hot request to the step stubs |
| step_done | input | 1 | Current step finished |
| step_err | input | 1 | Qualifies `step_done` as failed |
| lane_ierr | input | 1 | Intermittent error from the lanes during training |
| drift_evt | input | 1 | Drift error event |
| init_done_pin | output | 1 | Completion output, meaning picked by control bit 16 |

## Verification
The hardest states to reach are the ones where two rules meet in one cycle. Examples are a start written while a run is still in progress, an error on the last training step, and the flag-clearing command arriving while drift and training flags are set. The stimulus creates these with a step stub whose response latency and error position can be set per test. A second start is written in the middle of a stretched run. Drift and intermittent-error events are pulsed before the clear, so each rule is seen both acting and being left alone.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

  localparam int CW       = 32;
  localparam int NSTEP    = 8;
  localparam int PW       = $clog2(NSTEP + 1);
  localparam int ZC_POS   = 2;   // impedance calibration position
  localparam int TRN_POS  = 6;   // first training position

  // control word bit positions
  localparam int TRIG_BIT    = 0;
  localparam int EN_LO       = 1;
  localparam int MODE_BIT    = 16;
  localparam int DLLBYP_BIT  = 17;
  localparam int CTLINIT_BIT = 18;
  localparam int CLR_BIT     = 28;
  localparam int LOCKBYP_BIT = 29;
  localparam int ZCBYP_BIT   = 30;
  localparam int ALLBYP_BIT  = 31;

  localparam logic [CW-1:0] CTRL_WMASK = 32'hE007_01FE;

  typedef struct packed {
    logic busy;
    logic drift;
    logic tr_ierr;
    logic tr_err;
    logic tr_done;
    logic seq_err;
    logic phy_rdy;
    logic idone;
  } stat_t;

  localparam int SW = $bits(stat_t);

  // which step positions a control word selects
  function automatic logic [NSTEP-1:0] build_mask(input logic [CW-1:0] w, input logic lb);
    logic [NSTEP-1:0] m;
    m[0] = w[EN_LO]   & ~w[DLLBYP_BIT];
    m[1] = w[EN_LO+1] & ~w[DLLBYP_BIT] & ~w[LOCKBYP_BIT];
    m[2] = w[EN_LO+2] & ~w[ZCBYP_BIT];
    m[3] = w[EN_LO+3];
    m[4] = w[EN_LO+4];
    m[5] = w[EN_LO+5] & ~w[CTLINIT_BIT];
    m[6] = (w[EN_LO+6] | w[EN_LO+7]) & ~lb;
    m[7] = w[EN_LO+7];
    if (w[ALLBYP_BIT]) m = '0;
    return m;
  endfunction

  // lowest selected position at or above 'from', NSTEP when none
  function automatic logic [PW-1:0] next_pos(input logic [NSTEP-1:0] m, input logic [PW-1:0] from);
    logic [PW-1:0] r;
    r = PW'(NSTEP);
    for (int i = NSTEP - 1; i >= 0; i--)
      if (m[i] && (PW'(i) >= from)) r = PW'(i);
    return r;
  endfunction

  function automatic logic is_train(input logic [PW-1:0] p);
    return (p >= PW'(TRN_POS)) && (p < PW'(NSTEP));
  endfunction

endpackage

// File: rtl/pis_ctrl_reg.sv
module pis_ctrl_reg
  import phy_init_pkg::*;
#(
  parameter logic [CW-1:0] WMASK = CTRL_WMASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic          busy,
  output logic [CW-1:0] ctrl_q,
  output logic [CW-1:0] rb,
  output logic          clr_cmd,
  output logic          trig_cmd
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & WMASK;
  end

  assign rb       = ctrl_q | {{(CW-1){1'b0}}, busy};
  assign clr_cmd  = wr_en & wdata[CLR_BIT];
  assign trig_cmd = wr_en & wdata[TRIG_BIT];

endmodule

// File: rtl/pis_stepper.sv
module pis_stepper
  import phy_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NSTEP-1:0] start_mask,
  input  logic             done,
  input  logic             err,
  output logic             busy,
  output logic [NSTEP-1:0] req,
  output logic [PW-1:0]    cur_pos,
  output logic             adv,
  output logic             abort,
  output logic             fin,
  output logic             rdy_evt
);

  logic [NSTEP-1:0] mask_q;
  logic [PW-1:0]    cur_q;
  logic             busy_q;
  logic [PW-1:0]    first_w;
  logic [PW-1:0]    nxt_w;
  logic             accept_w;
  logic             last_w;

  assign first_w  = next_pos(start_mask, '0);
  assign nxt_w    = next_pos(mask_q, cur_q + 1'b1);
  assign accept_w = busy_q & done;
  assign last_w   = nxt_w == PW'(NSTEP);

  assign adv     = accept_w & ~err;
  assign abort   = accept_w & err;
  assign fin     = (start & (first_w == PW'(NSTEP))) | (accept_w & (err | last_w));
  assign rdy_evt = (start & (first_w > PW'(ZC_POS))) | (adv & (nxt_w > PW'(ZC_POS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cur_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      mask_q <= start_mask;
      cur_q  <= first_w;
      busy_q <= first_w != PW'(NSTEP);
    end else if (accept_w) begin
      if (err || last_w) busy_q <= 1'b0;
      else               cur_q  <= nxt_w;
    end
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_req
    assign req[g] = busy_q & (cur_q == PW'(g));
  end

  assign busy    = busy_q;
  assign cur_pos = cur_q;

endmodule

// File: rtl/pis_status.sv
module pis_status
  import phy_init_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  start_train,
  input  logic  fin,
  input  logic  abort,
  input  logic  rdy_evt,
  input  logic  adv_train,
  input  logic  abort_train,
  input  logic  ierr_evt,
  input  logic  drift_evt,
  input  logic  clr_cmd,
  input  logic  busy,
  output stat_t st
);

  logic idone_q, rdy_q, serr_q, trd_q, tre_q, tri_q, drift_q;
  logic tr_keep;

  assign tr_keep = ~clr_cmd & ~start_train;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idone_q <= 1'b0;
      rdy_q   <= 1'b0;
      serr_q  <= 1'b0;
      trd_q   <= 1'b0;
      tre_q   <= 1'b0;
      tri_q   <= 1'b0;
      drift_q <= 1'b0;
    end else begin
      if (fin)          idone_q <= 1'b1;
      else if (start)   idone_q <= 1'b0;
      if (rdy_evt)      rdy_q   <= 1'b1;
      else if (start)   rdy_q   <= 1'b0;
      if (abort)        serr_q  <= 1'b1;
      else if (start)   serr_q  <= 1'b0;
      trd_q   <= (trd_q & tr_keep) | adv_train;
      tre_q   <= (tre_q & tr_keep) | abort_train;
      tri_q   <= (tri_q & tr_keep) | ierr_evt;
      drift_q <= (drift_q & ~clr_cmd) | drift_evt;
    end
  end

  always_comb begin
    st.busy    = busy;
    st.drift   = drift_q;
    st.tr_ierr = tri_q;
    st.tr_err  = tre_q;
    st.tr_done = trd_q;
    st.seq_err = serr_q;
    st.phy_rdy = rdy_q;
    st.idone   = idone_q;
  end

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  CTRL_OFS = 8'h04,
  parameter logic [AW-1:0]  STAT_OFS = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [CW-1:0]    reg_wdata,
  output logic [CW-1:0]    reg_rdata,
  input  logic             lb_gate_only,
  output logic [NSTEP-1:0] step_req,
  input  logic             step_done,
  input  logic             step_err,
  input  logic             lane_ierr,
  input  logic             drift_evt,
  output logic             init_done_pin
);

  logic [CW-1:0]    ctrl_q, ctrl_rb_w;
  logic             ctrl_wr, clr_cmd, trig_cmd;
  logic             busy_w, start_w, start_train;
  logic [NSTEP-1:0] start_mask;
  logic [PW-1:0]    cur_pos;
  logic             cur_train;
  logic             adv, abort, fin, rdy_evt;
  stat_t            st;
  logic             idone_w, mode_w;

  assign ctrl_wr     = reg_wr && (reg_addr == CTRL_OFS);
  assign start_w     = trig_cmd & ~busy_w;
  assign start_mask  = build_mask(reg_wdata, lb_gate_only);
  assign start_train = start_w & (|start_mask[NSTEP-1:TRN_POS]);
  assign cur_train   = is_train(cur_pos);

  pis_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (reg_wdata),
    .busy     (busy_w),
    .ctrl_q   (ctrl_q),
    .rb       (ctrl_rb_w),
    .clr_cmd  (clr_cmd),
    .trig_cmd (trig_cmd)
  );

  pis_stepper u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_w),
    .start_mask (start_mask),
    .done       (step_done),
    .err        (step_err),
    .busy       (busy_w),
    .req        (step_req),
    .cur_pos    (cur_pos),
    .adv        (adv),
    .abort      (abort),
    .fin        (fin),
    .rdy_evt    (rdy_evt)
  );

  pis_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_w),
    .start_train (start_train),
    .fin         (fin),
    .abort       (abort),
    .rdy_evt     (rdy_evt),
    .adv_train   (adv & cur_train),
    .abort_train (abort & cur_train),
    .ierr_evt    (lane_ierr & busy_w & cur_train),
    .drift_evt   (drift_evt),
    .clr_cmd     (clr_cmd),
    .busy        (busy_w),
    .st          (st)
  );

  assign idone_w       = st.idone;
  assign mode_w        = ctrl_q[MODE_BIT];
  assign init_done_pin = mode_w ? st.idone : st.phy_rdy;

  always_comb begin
    if (reg_addr == CTRL_OFS)      reg_rdata = ctrl_rb_w;
    else if (reg_addr == STAT_OFS) reg_rdata = {{(CW-SW){1'b0}}, st};
    else                           reg_rdata = '0;
  end

endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] step_req,
  input logic         step_done,
  input logic         step_err,
  input logic         init_done_pin,
  input logic         busy_w,
  input logic         idone_w,
  input logic         mode_w
);

  // R3
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_req));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != '0 && !step_done) |=> $stable(step_req));

  // R3
  req_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != '0 && step_done && !step_err) |=> (step_req == '0 || step_req > $past(step_req)));

  // R6
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != '0 && step_done && step_err) |=> (step_req == '0 && idone_w));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> !idone_w);

  // R8
  mode_seq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w && busy_w) |-> !init_done_pin);

endmodule

bind phy_init_seq phy_init_seq_chk #(.N(phy_init_pkg::NSTEP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .step_req      (step_req),
  .step_done     (step_done),
  .step_err      (step_err),
  .init_done_pin (init_done_pin),
  .busy_w        (busy_w),
  .idone_w       (idone_w),
  .mode_w        (mode_w)
);

// File: tb/phy_init_seq_bench.sv
module phy_init_seq_bench;

  localparam logic [31:0] WM   = 32'hE007_01FE;
  localparam logic [7:0]  A_CT = 8'h04;
  localparam logic [7:0]  A_ST = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lb = 1'b0;
  logic [7:0]  req;
  logic        stub_done = 1'b0, stub_err = 1'b0, man_done = 1'b0, man_err = 1'b0;
  logic        done, err;
  logic        ierr = 1'b0, drift = 1'b0;
  logic        pin;

  always #10 clk = ~clk;   // 50 MHz

  assign done = stub_done | man_done;
  assign err  = stub_err | man_err;

  phy_init_seq u_phy_init_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .lb_gate_only(lb), .step_req(req), .step_done(done),
    .step_err(err), .lane_ierr(ierr), .drift_evt(drift), .init_done_pin(pin)
  );

  int total = 0, bad = 0, cyc = 0, ndone = 0, wcnt = 0, lat = 2;
  bit stub_en = 1'b1;
  logic [7:0] err_mask = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ctrl;
  bit m_busy, m_idone, m_rdy, m_serr, m_trd, m_tre, m_tri, m_drift;
  int m_q[$];

  function automatic void plan_steps(input logic [31:0] w, input logic l, ref int q[$]);
    q.delete();
    if (w[31]) return;
    if (w[1] && !w[17])           q.push_back(0);
    if (w[2] && !w[17] && !w[29]) q.push_back(1);
    if (w[3] && !w[30])           q.push_back(2);
    if (w[4])                     q.push_back(3);
    if (w[5])                     q.push_back(4);
    if (w[6] && !w[18])           q.push_back(5);
    if ((w[7] || w[8]) && !l)     q.push_back(6);
    if (w[8])                     q.push_back(7);
  endfunction

  always @(posedge clk) begin : ref_model
    bit was_busy;
    int pos;
    if (!rst_n) begin
      m_ctrl = '0; m_busy = 0; m_idone = 0; m_rdy = 0; m_serr = 0;
      m_trd = 0; m_tre = 0; m_tri = 0; m_drift = 0; m_q.delete();
    end else begin
      was_busy = m_busy;
      if (wr && addr == A_CT && wdata[28]) begin
        m_trd = 0; m_tre = 0; m_tri = 0; m_drift = 0;
      end
      if (drift) m_drift = 1;
      if (m_busy && ierr && m_q[0] >= 6) m_tri = 1;
      if (m_busy && done) begin
        pos = m_q.pop_front();
        if (err) begin
          m_serr = 1; if (pos >= 6) m_tre = 1;
          m_q.delete(); m_busy = 0; m_idone = 1;
        end else begin
          if (pos >= 6) m_trd = 1;
          if (m_q.size() == 0) begin m_busy = 0; m_idone = 1; m_rdy = 1; end
          else if (m_q[0] > 2) m_rdy = 1;
        end
      end
      if (wr && addr == A_CT) begin
        m_ctrl = wdata & WM;
        if (wdata[0] && !was_busy) begin
          plan_steps(wdata, lb, m_q);
          foreach (m_q[k]) if (m_q[k] >= 6) begin m_trd = 0; m_tre = 0; m_tri = 0; end
          m_idone = 0; m_serr = 0;
          if (m_q.size() == 0) begin m_idone = 1; m_rdy = 1; end
          else begin m_busy = 1; m_rdy = (m_q[0] > 2); end
        end
      end
    end
  end

  // per-cycle comparison, step stub and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 step request vs model", {24'h0, req}, m_busy ? (32'd1 << m_q[0]) : 32'd0);
      chk("R8 completion pin vs model", {31'h0, pin},
          {31'h0, (m_ctrl[16] ? m_idone : m_rdy)});
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin : stub
    if (stub_en) begin
      stub_done = 1'b0; stub_err = 1'b0;
      if (req != '0) begin
        wcnt++;
        if (wcnt >= lat) begin
          stub_done = 1'b1; stub_err = (req == err_mask); wcnt = 0; ndone++;
        end
      end else wcnt = 0;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); wr = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #2;
    chk(tag, rdata, exp);
    addr = '0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 control after reset", A_CT, 32'h0);
    rd_chk("R1 status after reset", A_ST, 32'h0);
    chk("R1 pin after reset", {31'h0, pin}, 32'h0);

    // full run, sequence-complete mode
    ndone = 0;
    wr_reg(A_CT, 32'h0001_01FF);
    rd_chk("R2 start bit reads 1 while busy", A_CT, 32'h0001_01FF);
    wait_idle();
    chk("R3 all eight steps handshaken", ndone, 8);
    rd_chk("R2 start bit reads 0 after run", A_CT, 32'h0001_01FE);
    rd_chk("R3 status after full run", A_ST, 32'h0B);
    chk("R8 pin in sequence mode after run", {31'h0, pin}, 32'h1);

    // bypasses remove everything
    ndone = 0;
    wr_reg(A_CT, 32'h4006_004F);
    wait_idle();
    chk("R4 dll/zcal/dram-init bypass leaves no step", ndone, 0);
    rd_chk("R4 empty run completes, training flags kept", A_ST, 32'h0B);

    ndone = 0;
    wr_reg(A_CT, 32'h2000_000F);
    wait_idle();
    chk("R4 lock bypass keeps soft reset and zcal", ndone, 2);

    ndone = 0;
    wr_reg(A_CT, 32'h8000_01FF);
    wait_idle();
    chk("R4 whole-init bypass", ndone, 0);
    rd_chk("R4 status after whole bypass", A_ST, 32'h0B);

    // RV pulls in gate training, loopback suppresses it
    ndone = 0;
    wr_reg(A_CT, 32'h0000_0101);
    wait_idle();
    chk("R5 RV alone runs gate and RV", ndone, 2);
    lb = 1'b1;
    ndone = 0;
    wr_reg(A_CT, 32'h0000_0101);
    wait_idle();
    lb = 1'b0;
    chk("R5 loopback leaves RV alone", ndone, 1);
    rd_chk("R11 training done after RV run", A_ST, 32'h0B);

    // error abort in the middle
    err_mask = 8'h08;
    ndone = 0;
    wr_reg(A_CT, 32'h0000_01FF);
    wait_idle();
    chk("R6 abort after failing timing reset", ndone, 4);
    rd_chk("R6 status after abort", A_ST, 32'h07);

    // error on RV training
    err_mask = 8'h80;
    ndone = 0;
    wr_reg(A_CT, 32'h0000_0181);
    wait_idle();
    err_mask = 8'h00;
    chk("R11 gate then failing RV", ndone, 2);
    rd_chk("R11 training error flags", A_ST, 32'h1F);

    // start written while busy
    lat = 4;
    ndone = 0;
    wr_reg(A_CT, 32'h0000_007F);
    repeat (5) @(negedge clk);
    wr_reg(A_CT, 32'h0000_0181);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R7 second start ignored", ndone, 6);
    rd_chk("R7 enables of ignored write stored", A_CT, 32'h0000_0180);
    rd_chk("R9 new init clears error, keeps training", A_ST, 32'h1B);

    // PHY-ready mode asserts during the run
    lat = 6;
    ndone = 0;
    wr_reg(A_CT, 32'h0000_003F);
    chk("R8 ready mode pin low after start", {31'h0, pin}, 32'h0);
    while (ndone < 3) @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R8 ready mode pin high past zcal", {31'h0, pin}, 32'h1);
    rd_chk("R2 busy readback mid-run", A_CT, 32'h0000_003F);
    wait_idle();

    // sequence mode holds pin low while busy
    wr_reg(A_CT, 32'h0001_0003);
    chk("R8 sequence mode pin low while busy", {31'h0, pin}, 32'h0);
    wait_idle();
    chk("R8 sequence mode pin high at end", {31'h0, pin}, 32'h1);

    // drift survives new init, clear command wipes it
    lat = 2;
    @(negedge clk); drift = 1'b1;
    @(negedge clk); drift = 1'b0;
    wr_reg(A_CT, 32'h0000_0003);
    wait_idle();
    rd_chk("R9 drift kept across new init", A_ST, 32'h5B);
    wr_reg(A_CT, 32'h1000_0000);
    rd_chk("R10 clear bit reads 0", A_CT, 32'h0);
    rd_chk("R10 clear wipes training and drift", A_ST, 32'h03);

    // intermittent error then a training run clearing it
    lat = 4;
    ierr = 1'b1;
    wr_reg(A_CT, 32'h0000_0081);
    wait_idle();
    ierr = 1'b0;
    rd_chk("R11 intermittent error during training", A_ST, 32'h2B);
    wr_reg(A_CT, 32'h0000_0181);
    wait_idle();
    rd_chk("R11 new training run clears flags", A_ST, 32'h0B);

    // stray handshake while idle
    stub_en = 1'b0;
    @(negedge clk); man_done = 1'b1; man_err = 1'b1;
    @(negedge clk); man_done = 1'b0; man_err = 1'b0;
    repeat (2) @(negedge clk);
    stub_en = 1'b1;
    rd_chk("R12 idle done leaves status", A_ST, 32'h0B);
    rd_chk("R12 idle done leaves control", A_CT, 32'h0000_0180);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule